// File: doc/BRIEF.md
# SMBus indexed block register target

This block is an SMBus target that holds a small bank of byte-wide configuration registers for a clock-distribution device. A system clock oversamples SCL and SDA. The block detects start, repeated start and stop conditions, shifts bytes in and out, and pulls SDA low through an open-drain enable for acknowledges and for read data. The register bank is presented as a flat vector so that downstream output-enable and clock-gating logic can use each field directly.

Every transfer begins with a starting register index. In a write, the host then sends a byte count and that many data bytes, which land in consecutive registers. In a read, the host issues a repeated start with the read address. The target answers first with the value of a writable count register and then streams registers from the chosen index onward until the host answers with a NACK. A stop or a fresh start ends a transfer at any point. Bytes that were already accepted stay written.

Top module: `smb_idxblk_target`

## Requirements
- R1: The address byte 0xDC (write) or 0xDD (read) is acknowledged. Any other address byte gets no ACK, and every later byte is ignored and left unacknowledged until the next start condition.
- R2: After reset the registers hold: reg0 = 0x07, reg1 = 0x66 (output enables at bits 6, 5, 2, 1), reg2 = 0x00, reg3 = 0x00, reg4 = 0x21, reg5 = 0x08, reg6 = 0x05. Register i appears on reg_bank_o[8*i+7:8*i].
- R3: A write of the form start, 0xDC, index N, count X, X data bytes stores the data bytes into registers N, N+1, and so on. The target ACKs the address, index, count and each of the X data bytes.
- R4: A data byte beyond the count X in a write is not acknowledged and is not stored.
- R5: A read of the form start, 0xDC, index N, repeated start, 0xDD returns the current value of reg6 first. It then returns registers N, N+1, and so on, for as long as the host ACKs. After the host NACKs, the target stops driving SDA.
- R6: reg4 is read-only. A write byte aimed at it is acknowledged, and its value stays 0x21.
- R7: Indexes at or beyond the register count (7) read as 0x00. A write byte aimed there is acknowledged and has no effect.
- R8: A stop or a start in the middle of a write ends the transfer. Data bytes acknowledged before it stay stored, and nothing after it is stored.
- R9: sda_oe_o = 1 pulls SDA low, and 0 releases it. The target never pulls SDA while the host drives a bit, and it changes the pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| reg_bank_o | output | 56 | All registers, register i in bits 8*i+7 to 8*i |

## Verification
The bench sweeps every start index against every legal length, writing through the block and reading the same span back. A pointer that did not increment, or a read that skipped the count byte, shows up as shifted data. It sends bytes past the write count and expects a NACK and an unchanged register, which catches a design that ignores the count. It cuts writes short with a stop and with a start and checks that the earlier bytes are kept and the later ones are dropped. It also writes the read-only register and indexes past the end of the bank, where a wrong decode would alter a neighbouring register. Wrong addresses are sent followed by more bytes, so a target that stayed awake after a mismatch would ACK them. While the host drives bits, the pull enable is monitored to catch a target that fights the host on the bus.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } xfer_st_e;

  typedef enum logic [1:0] {
    FLD_ADDR,
    FLD_INDEX,
    FLD_COUNT,
    FLD_DATA
  } rx_field_e;

  localparam logic [7:0] CNT_RESET = 8'h05;

  function automatic logic [7:0] reg_reset(input int idx, input logic [7:0] ro_val);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h07;
      1:       v = 8'h66;
      4:       v = ro_val;
      5:       v = 8'h08;
      6:       v = CNT_RESET;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic rx_field_e next_field(input rx_field_e f);
    rx_field_e n;
    case (f)
      FLD_ADDR:  n = FLD_INDEX;
      FLD_INDEX: n = FLD_COUNT;
      default:   n = FLD_DATA;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         NREG    = 7,
  parameter int         RO_IDX  = 4,
  parameter int         CNT_IDX = 6,
  parameter logic [7:0] RO_VAL  = 8'h21,
  localparam int        BANK_W  = NREG * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [7:0]        cnt_val,
  output logic [BANK_W-1:0] bank_o
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST_V = smb_idx_pkg::reg_reset(g, RO_VAL);
    if (g == RO_IDX) begin : g_ro
      assign bank_o[g*8 +: 8] = RST_V;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= RST_V;
        end else if (wr_en && (wr_idx == 8'(g))) begin
          q <= wr_data;
        end
      end
      assign bank_o[g*8 +: 8] = q;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == 8'(i)) rd_data = bank_o[i*8 +: 8];
    end
  end

  assign cnt_val = bank_o[CNT_IDX*8 +: 8];

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_idx_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h6E
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  input  logic [7:0] cnt_val,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx,
  output logic       sda_oe,
  output logic       idle
);

  xfer_st_e  state;
  rx_field_e field;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] ptr;
  logic [7:0] wleft;
  logic       rd_mode;
  logic       host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      field    <= FLD_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      wleft    <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        field  <= FLD_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (field)
                FLD_ADDR: begin
                  if (shreg[7:1] == TGT_ADDR) begin
                    rd_mode <= shreg[0];
                    sda_oe  <= 1'b1;
                    state   <= ST_RX_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                FLD_INDEX: begin
                  ptr    <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end
                FLD_COUNT: begin
                  wleft  <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end
                default: begin
                  if (wleft != 8'd0) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= shreg;
                    ptr     <= ptr + 8'd1;
                    wleft   <= wleft - 8'd1;
                    sda_oe  <= 1'b1;
                    state   <= ST_RX_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (field == FLD_ADDR && rd_mode) begin
                shreg  <= cnt_val;
                sda_oe <= ~cnt_val[7];
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                field  <= next_field(field);
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (host_ack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 8'd1;
                bitcnt <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx = ptr;
  assign idle   = (state == ST_IDLE);

endmodule

// File: rtl/smb_idxblk_target.sv
module smb_idxblk_target #(
  parameter int         NREG        = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] TGT_ADDR    = 7'h6E,
  parameter int         RO_IDX      = 4,
  parameter int         CNT_IDX     = 6,
  parameter logic [3:0] REV_ID      = 4'h2,
  parameter logic [3:0] VEND_ID     = 4'h1,
  localparam int        BANK_W      = NREG * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [BANK_W-1:0] reg_bank_o
);

  logic       scl_q;
  logic       sda_q;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic       wr_en;
  logic [7:0] wr_idx;
  logic [7:0] wr_data;
  logic [7:0] rd_idx;
  logic [7:0] rd_data;
  logic [7:0] cnt_val;
  logic       fsm_idle;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_xfer_fsm #(.TGT_ADDR(TGT_ADDR)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .cnt_val   (cnt_val),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .sda_oe    (sda_oe_o),
    .idle      (fsm_idle)
  );

  smb_regfile #(
    .NREG    (NREG),
    .RO_IDX  (RO_IDX),
    .CNT_IDX (CNT_IDX),
    .RO_VAL  ({REV_ID, VEND_ID})
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .cnt_val (cnt_val),
    .bank_o  (reg_bank_o)
  );

endmodule

// File: rtl/smb_idx_checker.sv
module smb_idx_checker #(
  parameter int         NREG   = 7,
  parameter int         RO_IDX = 4,
  parameter logic [7:0] RO_VAL = 8'h21
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_q,
  input logic              idle,
  input logic              sda_oe,
  input logic [NREG*8-1:0] bank
);

  logic [NREG*8-1:0] prev;
  logic [NREG-1:0]   chg;

  always_ff @(posedge clk) prev <= bank;

  for (genvar i = 0; i < NREG; i++) begin : g_chg
    assign chg[i] = (bank[i*8 +: 8] != prev[i*8 +: 8]);
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_q); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    idle |-> !sda_oe); // R1

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(bank)); // R8

  AST_ONE_BYTE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg)); // R3

  AST_RO_FIXED: assert property (@(posedge clk) disable iff (rst)
    bank[RO_IDX*8 +: 8] == RO_VAL); // R6

endmodule

bind smb_idxblk_target smb_idx_checker #(
  .NREG   (NREG),
  .RO_IDX (RO_IDX),
  .RO_VAL ({REV_ID, VEND_ID})
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .scl_q  (scl_q),
  .idle   (fsm_idle),
  .sda_oe (sda_oe_o),
  .bank   (reg_bank_o)
);

// File: tb/smb_idxblk_target_tb.sv
module smb_idxblk_target_tb_top;

  localparam int NREG = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic host_pull = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] bank;
  wire  sda_bus = ~(host_pull | sda_oe);

  int   ntests = 0;
  int   nfail  = 0;
  int   oe_bad = 0;
  bit   done   = 1'b0;

  logic [7:0] expv [NREG];
  logic [7:0] wbuf [16];
  logic       wack [16];
  logic [7:0] rbuf [16];
  logic [7:0] rcnt;
  logic       hdr_ok;
  logic       rel_ok;

  always #10 clk = ~clk;

  smb_idxblk_target dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .reg_bank_o (bank)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] ex);
    ntests++;
    if (act !== ex) begin
      nfail++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, ex);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++) check8(tag, bank[i*8 +: 8], expv[i]);
  endtask

  task automatic bus_start();
    host_pull = 1'b0; tick(5);
    scl = 1'b1;       tick(5);
    host_pull = 1'b1; tick(5);
    scl = 1'b0;       tick(5);
  endtask

  task automatic bus_stop();
    host_pull = 1'b1; tick(5);
    scl = 1'b1;       tick(5);
    host_pull = 1'b0; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_pull = ~b[i]; tick(5);
      scl = 1'b1;        tick(5);
      if (sda_oe) oe_bad++;
      tick(5);
      scl = 1'b0;        tick(5);
    end
    host_pull = 1'b0; tick(5);
    scl = 1'b1;       tick(5);
    ack = ~sda_bus;   tick(5);
    scl = 1'b0;       tick(5);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack_it);
    host_pull = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(5);
      scl = 1'b1; tick(5);
      b = {b[6:0], sda_bus};
      tick(5);
      scl = 1'b0;
    end
    host_pull = ack_it; tick(5);
    scl = 1'b1;         tick(10);
    scl = 1'b0;         tick(3);
    host_pull = 1'b0;
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt,
                           input int nsend, input bit do_stop);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hDC, a0);
    send_byte(idx, a1);
    send_byte(cnt, a2);
    hdr_ok = a0 & a1 & a2;
    for (int k = 0; k < nsend; k++) send_byte(wbuf[k], wack[k]);
    if (do_stop) bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n);
    logic a0, a1, a2;
    bus_start();
    send_byte(8'hDC, a0);
    send_byte(idx, a1);
    bus_start();
    send_byte(8'hDD, a2);
    hdr_ok = a0 & a1 & a2;
    recv_byte(rcnt, n != 0);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    tick(3);
    rel_ok = ~sda_oe;
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] bad_addr [6];
    expv[0] = 8'h07; expv[1] = 8'h66; expv[2] = 8'h00; expv[3] = 8'h00;
    expv[4] = 8'h21; expv[5] = 8'h08; expv[6] = 8'h05;
    bad_addr[0] = 8'h00; bad_addr[1] = 8'hA0; bad_addr[2] = 8'hDE;
    bad_addr[3] = 8'hDA; bad_addr[4] = 8'h5C; bad_addr[5] = 8'hFC;

    tick(10);
    rst = 1'b0;
    tick(10);

    // R2: reset contents at the port and through a read
    check_bank("R2 reset bank");
    check8("R5 release idle", {7'b0, sda_oe}, 8'h00);
    blk_read(8'd0, NREG);
    check8("R1 read header ack", {7'b0, hdr_ok}, 8'h01);
    check8("R5 count byte at reset", rcnt, 8'h05);
    for (int i = 0; i < NREG; i++) check8("R2 reset readback", rbuf[i], expv[i]);
    check8("R5 release after nack", {7'b0, rel_ok}, 8'h01);

    // R3 / R6: sweep of every start index and every fitting length
    for (int s = 0; s < NREG; s++) begin
      for (int len = 1; len <= NREG - s; len++) begin
        for (int k = 0; k < len; k++) wbuf[k] = 8'((s * 16 + k * 3 + len) ^ 8'h5A);
        blk_write(8'(s), 8'(len), len, 1'b1);
        check8("R3 write header ack", {7'b0, hdr_ok}, 8'h01);
        for (int k = 0; k < len; k++) begin
          check8((s + k == 4) ? "R6 ro write ack" : "R3 data ack", {7'b0, wack[k]}, 8'h01);
          if (s + k != 4) expv[s + k] = wbuf[k];
        end
        check8("R6 ro value", bank[39:32], 8'h21);
        blk_read(8'(s), len);
        check8("R5 count from reg6", rcnt, expv[6]);
        for (int k = 0; k < len; k++) check8("R3 readback", rbuf[k], expv[s + k]);
        check8("R5 release", {7'b0, rel_ok}, 8'h01);
      end
    end
    check_bank("R3 bank after sweep");

    // R4: byte past the count
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    blk_write(8'd1, 8'd2, 3, 1'b1);
    expv[1] = 8'h11; expv[2] = 8'h22;
    check8("R4 in-count ack", {7'b0, wack[1]}, 8'h01);
    check8("R4 extra byte nack", {7'b0, wack[2]}, 8'h00);
    check_bank("R4 bank");

    // R7: index past the bank
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    blk_write(8'd7, 8'd2, 2, 1'b1);
    check8("R7 write ack", {7'b0, wack[0] & wack[1]}, 8'h01);
    check_bank("R7 bank unchanged");
    blk_read(8'd5, 4);
    check8("R7 read reg5", rbuf[0], expv[5]);
    check8("R7 read reg6", rbuf[1], expv[6]);
    check8("R7 read past end", rbuf[2], 8'h00);
    check8("R7 read past end", rbuf[3], 8'h00);

    // R1: foreign addresses and the bytes that follow them
    for (int i = 0; i < 6; i++) begin
      bus_start();
      send_byte(bad_addr[i], a);
      check8("R1 foreign address nack", {7'b0, a}, 8'h00);
      send_byte(8'h01, a);
      check8("R1 ignored after nack", {7'b0, a}, 8'h00);
      send_byte(8'h3C, a);
      check8("R1 ignored after nack", {7'b0, a}, 8'h00);
      bus_stop();
    end
    check_bank("R1 bank unchanged");

    // R8: abort by stop, then by start
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    blk_write(8'd0, 8'd3, 2, 1'b1);
    expv[0] = 8'hC1; expv[1] = 8'hC2;
    check_bank("R8 stop abort");
    wbuf[0] = 8'hD3;
    blk_write(8'd2, 8'd2, 1, 1'b0);
    expv[2] = 8'hD3;
    bus_start();
    send_byte(8'h77, a);
    check8("R8 byte after start is address", {7'b0, a}, 8'h00);
    send_byte(8'h66, a);
    check8("R8 nothing after abort", {7'b0, a}, 8'h00);
    bus_stop();
    check_bank("R8 start abort");

    // R5: count byte follows reg6
    wbuf[0] = 8'h02;
    blk_write(8'd6, 8'd1, 1, 1'b1);
    expv[6] = 8'h02;
    blk_read(8'd0, 3);
    check8("R5 count after reg6 write", rcnt, 8'h02);
    for (int k = 0; k < 3; k++) check8("R5 data after count", rbuf[k], expv[k]);
    check8("R5 release", {7'b0, rel_ok}, 8'h01);

    // R9: target never pulled SDA during host bits
    check8("R9 no pull during host bits", 8'(oe_bad), 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule